// File: doc/BRIEF.md
# Ethernet PHY Link Status Resolver

This block keeps a MAC's view of the link in step with what an attached Ethernet PHY reports. On each poll pulse it walks through up to three PHY register reads, one at a time, over a simple request/acknowledge port to an external management master. It then settles link state, speed, duplex and interface mode, and updates the MAC-side controls. The serial management wire protocol is handled outside the block.

From the reads it resolves speed and duplex by priority. Gigabit partner ability comes first; the 10/100 partner ability field of register 5 is used only when no gigabit ability is reported. It adjusts the interface-mode code to match, follows the partner's pause ability with a flow-control enable, and emits one-cycle pulses that open or close the MAC transmit/receive paths on link transitions. The MAC status word is written only when it changes. When autonegotiation is off, the configured speed and duplex replace the resolved ones in the status word. The resolved values stay visible on separate outputs.

Top module: `phy_link_resolver`

## Requirements
- R1: After reset, `stat_word`, `fc_en`, `det_speed`, `det_duplex`, `rd_req` and every pulse output are 0, and the stored link state is down.
- R2: A poll pulse in idle starts one pass and a poll during a pass is ignored. Each pass reads register 1 first, with only one request outstanding, and `rd_req`/`rd_reg` hold until `rd_ack`. If bit 2 of register 1 is 0 the link is down and the pass ends after that read. Otherwise register 10 and then register 5 are read.
- R3: On a link-up pass, register 10 bit 11 set gives speed 2 (1000 Mb/s) and duplex 1 (full). If bit 11 is clear and bit 10 is set, the result is speed 2 and duplex 0 (half).
- R4: With neither gigabit bit set, the partner field (register 5 AND 0x05E0, shifted right by 5) is tested in priority order. Its bit 3 (register bit 8) gives speed 1, duplex 1. Bit 2 (register bit 7) gives speed 1, duplex 0. Bit 1 (register bit 6) gives speed 0, duplex 1. Bit 0 (register bit 5) gives speed 0, duplex 0. If none is set, the previous detected speed and duplex are kept.
- R5: The interface-mode field is taken from `cfg_if_mode`. On a gigabit result, code 2 becomes 3. On a link-up 10/100 result, code 3 becomes 2. All other codes, and link-down passes, leave it unchanged.
- R6: On link-up passes, `fc_en` takes bit 5 of the shifted partner field (register 5 bit 10). `fc_we` pulses only when `fc_en` changes. Link-down passes leave `fc_en` alone.
- R7: `path_en` pulses on a pass that finds the link up after it was down. `path_dis` pulses on a pass that finds it down after it was up.
- R8: With `autoneg_en` = 0, the status word carries `cfg_speed` and `cfg_duplex`. `det_speed`/`det_duplex` still show the resolved values.
- R9: `stat_word` layout: bit 0 link, bit 1 duplex, bits 3:2 speed, bits 5:4 interface mode, bit 6 zero. `stat_we` pulses, and the word changes, only when the new word differs from the stored one.
- R10: `done` pulses for one cycle per pass. It comes together with any `stat_we`, `fc_we`, `path_en` or `path_dis` pulse, two cycles after the cycle in which the last `rd_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll | input | 1 | Start a resolution pass |
| autoneg_en | input | 1 | 1: status carries resolved speed/duplex |
| cfg_speed | input | 2 | Forced speed when autonegotiation is off |
| cfg_duplex | input | 1 | Forced duplex when autonegotiation is off |
| cfg_if_mode | input | 2 | Base interface-mode code |
| cfg_phy_addr | input | 5 | PHY address used for every read |
| rd_req | output | 1 | Register read request |
| rd_phy | output | 5 | PHY address of the request |
| rd_reg | output | 5 | Register number of the request |
| rd_ack | input | 1 | Read complete, data valid |
| rd_data | input | 16 | Read data |
| stat_we | output | 1 | MAC status write strobe |
| stat_word | output | 7 | MAC status word |
| fc_we | output | 1 | MAC flow-control write strobe (covers both enables) |
| fc_en | output | 1 | Transmit and receive flow-control enable |
| path_en | output | 1 | Enable MAC transmit/receive paths |
| path_dis | output | 1 | Disable MAC transmit/receive paths |
| det_speed | output | 2 | Resolved speed |
| det_duplex | output | 1 | Resolved duplex |
| done | output | 1 | Pass finished |

## Verification
Each read request appears in the cycle after the poll is sampled or after the previous acknowledge. All results of a pass (status word, strobes, path pulses, detected values, `done`) are due together exactly two cycles after the final acknowledge is sampled. The bench records the cycle of every acknowledge and checks that `done` rises at that distance. It compares the pass results on the `done` cycle and, on every other clock, checks that all strobes and pulses stay low.

// File: rtl/plr_pkg.sv
package plr_pkg;
  localparam int DATA_W = 16;
  localparam int REGA_W = 5;
  localparam int PHYA_W = 5;
  localparam int ABIL_W = 6;
  localparam int ABIL_SH = 5;

  localparam logic [REGA_W-1:0] REG_BASIC   = 5'd1;
  localparam logic [REGA_W-1:0] REG_GIG     = 5'd10;
  localparam logic [REGA_W-1:0] REG_PARTNER = 5'd5;

  localparam logic [DATA_W-1:0] GIG_FD_MASK = 16'h0800;
  localparam logic [DATA_W-1:0] GIG_HD_MASK = 16'h0400;
  localparam logic [DATA_W-1:0] ABIL_MASK   = 16'h05E0;
  localparam int LINK_BIT = 2;
  localparam int PAUSE_BIT = 5;

  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;
  localparam logic [1:0] MODE_A   = 2'd2;
  localparam logic [1:0] MODE_G   = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LINK, S_GIG, S_ABIL, S_COMMIT} seq_t;

  typedef struct packed {
    logic       spare;
    logic [1:0] mode;
    logic [1:0] speed;
    logic       duplex;
    logic       link;
  } stat_t;

  typedef struct packed {
    logic       found;
    logic       gig;
    logic [1:0] speed;
    logic       duplex;
  } res_t;

  function automatic logic link_of(input logic [DATA_W-1:0] w);
    return w[LINK_BIT];
  endfunction

  function automatic logic [1:0] gig_of(input logic [DATA_W-1:0] w);
    return {|(w & GIG_FD_MASK), |(w & GIG_HD_MASK)};
  endfunction

  function automatic logic [ABIL_W-1:0] abil_of(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] t;
    t = (w & ABIL_MASK) >> ABIL_SH;
    return t[ABIL_W-1:0];
  endfunction

  function automatic res_t resolve(input logic [1:0] g, input logic [ABIL_W-1:0] a);
    res_t r;
    r = '0;
    if (g[1])      begin r.found = 1'b1; r.gig = 1'b1; r.speed = SPD_1000; r.duplex = 1'b1; end
    else if (g[0]) begin r.found = 1'b1; r.gig = 1'b1; r.speed = SPD_1000; r.duplex = 1'b0; end
    else if (a[3]) begin r.found = 1'b1; r.speed = SPD_100; r.duplex = 1'b1; end
    else if (a[2]) begin r.found = 1'b1; r.speed = SPD_100; r.duplex = 1'b0; end
    else if (a[1]) begin r.found = 1'b1; r.speed = SPD_10;  r.duplex = 1'b1; end
    else if (a[0]) begin r.found = 1'b1; r.speed = SPD_10;  r.duplex = 1'b0; end
    return r;
  endfunction

  function automatic logic [1:0] mode_swap(input logic [1:0] code, input logic gig);
    if (gig && code == MODE_A) return MODE_G;
    if (!gig && code == MODE_G) return MODE_A;
    return code;
  endfunction
endpackage

// File: rtl/plr_seq.sv
module plr_seq
  import plr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll,
  input  logic                rd_ack,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                rd_req,
  output logic [REGA_W-1:0]   rd_reg,
  output logic                link_ok,
  output logic [1:0]          gig,
  output logic [ABIL_W-1:0]   abil,
  output logic                commit
);
  seq_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      link_ok <= 1'b0;
      gig     <= '0;
      abil    <= '0;
    end else begin
      case (state)
        S_IDLE: if (poll) state <= S_LINK;
        S_LINK: if (rd_ack) begin
          link_ok <= link_of(rd_data);
          state   <= link_of(rd_data) ? S_GIG : S_COMMIT;
        end
        S_GIG: if (rd_ack) begin
          gig   <= gig_of(rd_data);
          state <= S_ABIL;
        end
        S_ABIL: if (rd_ack) begin
          abil  <= abil_of(rd_data);
          state <= S_COMMIT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_GIG:   rd_reg = REG_GIG;
      S_ABIL:  rd_reg = REG_PARTNER;
      default: rd_reg = REG_BASIC;
    endcase
  end

  assign rd_req = (state == S_LINK) || (state == S_GIG) || (state == S_ABIL);
  assign commit = (state == S_COMMIT);
endmodule

// File: rtl/plr_decode.sv
module plr_decode
  import plr_pkg::*;
(
  input  logic              link_ok,
  input  logic [1:0]        gig,
  input  logic [ABIL_W-1:0] abil,
  input  logic [1:0]        cfg_if_mode,
  input  logic              autoneg_en,
  input  logic [1:0]        cfg_speed,
  input  logic              cfg_duplex,
  input  logic [1:0]        cur_speed,
  input  logic              cur_duplex,
  input  logic              cur_fc,
  output logic [1:0]        nxt_speed,
  output logic              nxt_duplex,
  output logic              nxt_fc,
  output stat_t             nxt_word
);
  res_t res;

  always_comb begin
    res        = resolve(gig, abil);
    nxt_speed  = (link_ok && res.found) ? res.speed  : cur_speed;
    nxt_duplex = (link_ok && res.found) ? res.duplex : cur_duplex;
    nxt_fc     = link_ok ? abil[PAUSE_BIT] : cur_fc;
    nxt_word        = '0;
    nxt_word.link   = link_ok;
    nxt_word.mode   = link_ok ? mode_swap(cfg_if_mode, res.gig) : cfg_if_mode;
    nxt_word.speed  = autoneg_en ? nxt_speed  : cfg_speed;
    nxt_word.duplex = autoneg_en ? nxt_duplex : cfg_duplex;
  end
endmodule

// File: rtl/plr_state.sv
module plr_state
  import plr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       link_ok,
  input  logic [1:0] nxt_speed,
  input  logic       nxt_duplex,
  input  logic       nxt_fc,
  input  stat_t      nxt_word,
  output stat_t      word_q,
  output logic       stat_we,
  output logic       fc_q,
  output logic       fc_we,
  output logic       path_en,
  output logic       path_dis,
  output logic [1:0] speed_q,
  output logic       duplex_q,
  output logic       done
);
  logic link_q;
  logic word_diff, fc_diff, link_rise, link_fall;

  assign word_diff = (nxt_word != word_q);
  assign fc_diff   = (nxt_fc != fc_q);
  assign link_rise = link_ok && !link_q;
  assign link_fall = !link_ok && link_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      fc_q     <= 1'b0;
      link_q   <= 1'b0;
      speed_q  <= '0;
      duplex_q <= 1'b0;
      stat_we  <= 1'b0;
      fc_we    <= 1'b0;
      path_en  <= 1'b0;
      path_dis <= 1'b0;
      done     <= 1'b0;
    end else begin
      stat_we  <= commit && word_diff;
      fc_we    <= commit && fc_diff;
      path_en  <= commit && link_rise;
      path_dis <= commit && link_fall;
      done     <= commit;
      if (commit) begin
        word_q   <= nxt_word;
        fc_q     <= nxt_fc;
        link_q   <= link_ok;
        speed_q  <= nxt_speed;
        duplex_q <= nxt_duplex;
      end
    end
  end
endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
  import plr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll,
  input  logic              autoneg_en,
  input  logic [1:0]        cfg_speed,
  input  logic              cfg_duplex,
  input  logic [1:0]        cfg_if_mode,
  input  logic [PHYA_W-1:0] cfg_phy_addr,
  output logic              rd_req,
  output logic [PHYA_W-1:0] rd_phy,
  output logic [REGA_W-1:0] rd_reg,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              stat_we,
  output logic [6:0]        stat_word,
  output logic              fc_we,
  output logic              fc_en,
  output logic              path_en,
  output logic              path_dis,
  output logic [1:0]        det_speed,
  output logic              det_duplex,
  output logic              done
);
  logic              link_ok, commit;
  logic [1:0]        gig;
  logic [ABIL_W-1:0] abil;
  logic [1:0]        nxt_speed;
  logic              nxt_duplex, nxt_fc;
  stat_t             nxt_word, word_q;

  assign rd_phy = cfg_phy_addr;

  plr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .poll(poll), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_req(rd_req), .rd_reg(rd_reg), .link_ok(link_ok), .gig(gig), .abil(abil),
    .commit(commit)
  );

  plr_decode u_dec (
    .link_ok(link_ok), .gig(gig), .abil(abil), .cfg_if_mode(cfg_if_mode),
    .autoneg_en(autoneg_en), .cfg_speed(cfg_speed), .cfg_duplex(cfg_duplex),
    .cur_speed(det_speed), .cur_duplex(det_duplex), .cur_fc(fc_en),
    .nxt_speed(nxt_speed), .nxt_duplex(nxt_duplex), .nxt_fc(nxt_fc), .nxt_word(nxt_word)
  );

  plr_state u_st (
    .clk(clk), .rst_n(rst_n), .commit(commit), .link_ok(link_ok),
    .nxt_speed(nxt_speed), .nxt_duplex(nxt_duplex), .nxt_fc(nxt_fc), .nxt_word(nxt_word),
    .word_q(word_q), .stat_we(stat_we), .fc_q(fc_en), .fc_we(fc_we),
    .path_en(path_en), .path_dis(path_dis), .speed_q(det_speed), .duplex_q(det_duplex),
    .done(done)
  );

  assign stat_word = word_q;
endmodule

// File: rtl/plr_checker.sv
module plr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req,
  input logic       rd_ack,
  input logic [4:0] rd_reg,
  input logic [6:0] stat_word,
  input logic       stat_we,
  input logic       fc_en,
  input logic       fc_we,
  input logic       path_en,
  input logic       path_dis,
  input logic       done
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_reg)); // R2
  AST_WORD_CHANGE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word != $past(stat_word)) |-> stat_we); // R9
  AST_WRITE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (stat_word != $past(stat_word))); // R9
  AST_FC_WRITE_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fc_we |-> (fc_en != $past(fc_en))); // R6
  AST_FC_TOGGLE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en != $past(fc_en)) |-> fc_we); // R6
  AST_EN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    path_en |-> stat_word[0] && !$past(stat_word[0])); // R7
  AST_DIS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    path_dis |-> !stat_word[0] && $past(stat_word[0])); // R7
  AST_PULSES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we || fc_we || path_en || path_dis) |-> done); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind phy_link_resolver plr_checker u_chk (.*);

// File: tb/tb_phy_link_resolver.sv
`timescale 1ns/1ps
module tb_phy_link_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll = 1'b0;
  logic autoneg_en = 1'b1;
  logic [1:0] cfg_speed = 2'd0;
  logic cfg_duplex = 1'b0;
  logic [1:0] cfg_if_mode = 2'd0;
  logic [4:0] cfg_phy_addr = 5'd7;
  logic rd_req, rd_ack = 1'b0;
  logic [4:0] rd_phy, rd_reg;
  logic [15:0] rd_data = 16'h0;
  logic stat_we, fc_we, fc_en, path_en, path_dis, det_duplex, done;
  logic [6:0] stat_word;
  logic [1:0] det_speed;

  phy_link_resolver dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, last_ack_cyc = 0, wait_cnt = 0;
  bit in_pass = 0;
  logic [15:0] ph_basic = 16'h0, ph_gig = 16'h0, ph_part = 16'h0;
  int reads[$];
  // reference state
  int m_word = 0, m_fc = 0, m_link = 0, m_spd = 0, m_dup = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // PHY responder, latency 2 cycles
  initial forever begin
    @(negedge clk);
    cyc++;
    rd_ack = 1'b0;
    if (rst_n && rd_req) begin
      if (wait_cnt == 2) begin
        rd_ack = 1'b1;
        rd_data = (rd_reg == 5'd1) ? ph_basic : (rd_reg == 5'd10) ? ph_gig :
                  (rd_reg == 5'd5) ? ph_part : 16'hDEAD;
        reads.push_back(int'(rd_reg));
        last_ack_cyc = cyc;
        wait_cnt = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  // every-clock comparison outside the result cycle
  initial forever begin
    @(negedge clk);
    if (rst_n && !done) begin
      chk("R10", "strobes idle", int'({stat_we, fc_we, path_en, path_dis}), 0);
    end
    if (rst_n && done && !in_pass) chk("R2", "unexpected done", 1, 0);
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  task automatic run_pass(string tag, bit extra_poll);
    int link, gigr, spd, dup, mode, fc, word, nreads, t;
    link = ph_basic[2];
    gigr = 0; spd = m_spd; dup = m_dup; fc = m_fc; mode = cfg_if_mode;
    if (link == 1) begin
      case (1'b1)
        ph_gig[11]:  begin spd = 2; dup = 1; gigr = 1; end
        ph_gig[10]:  begin spd = 2; dup = 0; gigr = 1; end
        ph_part[8]:  begin spd = 1; dup = 1; end
        ph_part[7]:  begin spd = 1; dup = 0; end
        ph_part[6]:  begin spd = 0; dup = 1; end
        ph_part[5]:  begin spd = 0; dup = 0; end
        default: ;
      endcase
      if (gigr == 1 && mode == 2) mode = 3;
      else if (gigr == 0 && mode == 3) mode = 2;
      fc = ph_part[10];
    end
    word = link + 2 * (autoneg_en ? dup : cfg_duplex) + 4 * (autoneg_en ? spd : cfg_speed) + 16 * mode;
    nreads = link ? 3 : 1;
    reads.delete();
    in_pass = 1;
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    if (extra_poll) begin
      @(negedge clk); @(negedge clk);
      poll = 1'b1;
      @(negedge clk);
      poll = 1'b0;
    end
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk(tag, "done seen", int'(done), 1);
    chk("R10", "done latency", cyc - last_ack_cyc, 2);
    chk("R2", "read count", reads.size(), nreads);
    if (reads.size() >= 1) chk("R2", "first read reg", reads[0], 1);
    if (nreads == 3 && reads.size() == 3) begin
      chk("R2", "second read reg", reads[1], 10);
      chk("R2", "third read reg", reads[2], 5);
    end
    chk("R2", "rd_phy", int'(rd_phy), int'(cfg_phy_addr));
    chk(tag, "stat_word", int'(stat_word), word);
    chk("R9", "stat_we", int'(stat_we), int'(word != m_word));
    chk("R6", "fc_en", int'(fc_en), fc);
    chk("R6", "fc_we", int'(fc_we), int'(fc != m_fc));
    chk("R7", "path_en", int'(path_en), int'(link == 1 && m_link == 0));
    chk("R7", "path_dis", int'(path_dis), int'(link == 0 && m_link == 1));
    chk(tag, "det_speed", int'(det_speed), spd);
    chk(tag, "det_duplex", int'(det_duplex), dup);
    m_word = word; m_fc = fc; m_link = link; m_spd = spd; m_dup = dup;
    @(negedge clk);
    in_pass = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while in reset and just after
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "stat_word", int'(stat_word), 0);
    chk("R1", "fc_en", int'(fc_en), 0);
    chk("R1", "det", int'({det_speed, det_duplex}), 0);
    chk("R1", "rd_req", int'(rd_req), 0);
    chk("R1", "pulses", int'({stat_we, fc_we, path_en, path_dis, done}), 0);
    // link down from reset: no write, no disable
    ph_basic = 16'h0000; run_pass("R1", 0);
    // gigabit full with pause, mode 2 -> 3
    cfg_if_mode = 2; ph_basic = 16'h0004; ph_gig = 16'h0C00; ph_part = 16'h0400;
    run_pass("R3", 0);
    run_pass("R9", 0);                                  // unchanged, no writes
    ph_gig = 16'h0400; run_pass("R3", 0);               // gigabit half
    cfg_if_mode = 3; ph_gig = 16'h0; ph_part = 16'h0180; run_pass("R5", 0); // 100 full, 3->2, fc off
    ph_part = 16'h00A0; run_pass("R4", 0);              // 100 half over 10 half
    ph_part = 16'h0060; run_pass("R4", 0);              // 10 full
    ph_part = 16'h0420; run_pass("R4", 0);              // 10 half, pause on
    ph_part = 16'h0000; run_pass("R4", 0);              // nothing: keep detected
    cfg_if_mode = 1; ph_gig = 16'h0800; run_pass("R5", 0); // code 1 unchanged
    autoneg_en = 0; cfg_speed = 1; cfg_duplex = 0; run_pass("R8", 0);
    cfg_if_mode = 2; ph_gig = 16'h0; ph_part = 16'h0040; run_pass("R5", 0); // 10/100 keeps 2
    ph_basic = 16'h0000; run_pass("R7", 0);             // link down: disable
    autoneg_en = 1; ph_basic = 16'h0004; ph_gig = 16'h0800; run_pass("R2", 1); // poll while busy
    ph_basic = 16'h0000; run_pass("R7", 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule